// File: doc/BRIEF.md
# Code-Protect-Aware Image Checksum Engine

This block forms a 16-bit verification checksum over a flash image that arrives one word per valid cycle. The image order is fixed: every program word from the lowest address up (1024 by default), then the configuration word, then the user-ID words (four by default). A start pulse opens a computation. The engine counts accepted words to decide which part of the image each word belongs to. Each word is added into a 16-bit accumulator that wraps on overflow.

A code-protect input is captured at the start pulse and selects one of two formulas. In open mode the program words are summed and the configuration word is added after masking with the open-mode mask. In protected mode the program words contribute nothing. The configuration word is masked with the protected-mode mask, and the low nibble of each user ID is packed into one 16-bit value. The first ID lands in the top nibble and the last ID in the bottom nibble. The two masks, the nibble width, the packing order and all counts are parameters.

A done flag rises the cycle after the last user-ID word is accepted. The result stays on the output until the next start. The memory controller or a test harness supplies the stream.

Top module: `cksum_engine`

## Requirements
- R1: After reset, `done_o` is 0 and `sum_o` is 0x0000.
- R2: In open mode (`protect_i`=0 at start), the result is the sum of all 1024 program words plus (configuration word AND 0x3F79), taken modulo 2^16. An image of 0x3FFF in every program word and the configuration word gives 0x3B79. The same image with 0x25E6 at the first and the last program word gives 0x0747.
- R3: In protected mode (`protect_i`=1 at start), the result is (configuration word AND 0x3F39) plus the packed user-ID value, modulo 2^16. Configuration 0x3F7F with IDs 5, 7, 3, 2 gives 0x966B.
- R4: In the packed user-ID value, only bits [3:0] of each ID word count. The ID that arrives first is shifted left by 12, the second by 8, the third by 4 and the fourth by 0.
- R5: The accumulator is 16 bits wide, and carries out of bit 15 are dropped.
- R6: `done_o` goes high in the cycle after the 1029th accepted word and not earlier. Cycles with `word_valid_i` low between words do not count.
- R7: Once `done_o` is high, `sum_o` and `done_o` stay unchanged until the next start pulse. Valid words presented while no computation is running have no effect.
- R8: A start pulse clears `done_o` and `sum_o` to 0 in the next cycle. It restarts the word count even in the middle of an image. A word presented in the same cycle as start is dropped.
- R9: The protect mode is captured at the start pulse. Changes on `protect_i` during the stream do not affect the result.
- R10: User-ID words add nothing in open mode, and program words add nothing in protected mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins a new computation |
| protect_i | input | 1 | Code-protect mode, captured at start (1 = protected) |
| word_valid_i | input | 1 | Qualifies `word_i` for one accepted word |
| word_i | input | 14 | Image word, in image order |
| sum_o | output | 16 | Checksum accumulator; final when `done_o` is high |
| done_o | output | 1 | Result ready; held until the next start |

## Verification
Three images with known answers, one per formula, exercise R2 and R3. These images would expose a wrong mask, a wrong packing shift, or a carry that leaks past 16 bits. Further images put large values in the fields that the active formula must ignore. A design that summed user IDs in open mode, or program words in protected mode, would return a nonzero or shifted checksum. Idle gaps in the stream, a restart halfway through an image, and a protect toggle mid-stream would catch a counter that advances on invalid cycles, a restart that leaves stale state behind, or a mode that is read live. Extra words sent after completion would catch a result that keeps accumulating. The done flag is sampled one word before the end, which catches an off-by-one in the word count.

// File: rtl/cksum_pkg.sv
package cksum_pkg;

   // Image segment that the next accepted word belongs to
   typedef enum logic [1:0] {
      SEG_IDLE = 2'd0,
      SEG_PROG = 2'd1,
      SEG_CFG  = 2'd2,
      SEG_UID  = 2'd3
   } seg_e;

endpackage

// File: rtl/cksum_seq.sv
module cksum_seq
   import cksum_pkg::*;
#(
   parameter int unsigned PROG_WORDS = 1024,
   parameter int unsigned UID_WORDS  = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic valid_i,
   output logic busy_o,
   output seg_e seg_o,
   output logic [((UID_WORDS > 1) ? $clog2(UID_WORDS) : 1)-1:0] uid_idx_o,
   output logic take_o,
   output logic last_o,
   output logic done_o
);

   localparam int unsigned TOTAL  = PROG_WORDS + 1 + UID_WORDS;
   localparam int unsigned CNT_W  = $clog2(TOTAL + 1);
   localparam int unsigned UIDX_W = (UID_WORDS > 1) ? $clog2(UID_WORDS) : 1;

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic             done_q;
   logic [CNT_W-1:0] uid_off;

   assign uid_off   = cnt_q - CNT_W'(PROG_WORDS + 1);
   assign uid_idx_o = uid_off[UIDX_W-1:0];
   assign take_o    = valid_i & busy_q & ~start_i;
   assign last_o    = (cnt_q == CNT_W'(TOTAL - 1));
   assign busy_o    = busy_q;
   assign done_o    = done_q;

   always_comb begin
      if (!busy_q)
         seg_o = SEG_IDLE;
      else if (cnt_q < CNT_W'(PROG_WORDS))
         seg_o = SEG_PROG;
      else if (cnt_q == CNT_W'(PROG_WORDS))
         seg_o = SEG_CFG;
      else
         seg_o = SEG_UID;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else if (start_i) begin
         cnt_q  <= '0;
         busy_q <= 1'b1;
         done_q <= 1'b0;
      end else if (take_o) begin
         if (last_o) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // Done and busy are never high together
   assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !busy_q);

   // Done rises only from acceptance of the final word
   assert_done_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> $past(take_o && last_o));

endmodule

// File: rtl/cksum_term.sv
module cksum_term
   import cksum_pkg::*;
#(
   parameter int unsigned WORD_W         = 14,
   parameter int unsigned SUM_W          = 16,
   parameter int unsigned UID_WORDS      = 4,
   parameter int unsigned NIB_W          = 4,
   parameter int unsigned PACK_MSB_FIRST = 1,
   parameter int unsigned MASK_OPEN      = 'h3F79,
   parameter int unsigned MASK_PROT      = 'h3F39,
   parameter int unsigned UIDX_W         = 2
) (
   input  seg_e              seg_i,
   input  logic              prot_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic [UIDX_W-1:0] uid_idx_i,
   output logic [SUM_W-1:0]  term_o
);

   localparam logic [SUM_W-1:0] M_OPEN = SUM_W'(MASK_OPEN);
   localparam logic [SUM_W-1:0] M_PROT = SUM_W'(MASK_PROT);

   logic [SUM_W-1:0] wide_word;
   logic [SUM_W-1:0] uid_lane [UID_WORDS];
   logic [SUM_W-1:0] uid_term;

   assign wide_word = SUM_W'(word_i);

   // One shifted copy of the ID nibble per position; the sequencer picks one
   for (genvar g = 0; g < UID_WORDS; g++) begin : g_lane
      if (PACK_MSB_FIRST != 0) begin : g_msb
         localparam int unsigned SH = NIB_W * (UID_WORDS - 1 - g);
         assign uid_lane[g] = SUM_W'(word_i[NIB_W-1:0]) << SH;
      end else begin : g_lsb
         localparam int unsigned SH = NIB_W * g;
         assign uid_lane[g] = SUM_W'(word_i[NIB_W-1:0]) << SH;
      end
   end

   assign uid_term = uid_lane[uid_idx_i];

   always_comb begin
      unique case (seg_i)
         SEG_PROG: term_o = prot_i ? '0 : wide_word;
         SEG_CFG:  term_o = wide_word & (prot_i ? M_PROT : M_OPEN);
         SEG_UID:  term_o = prot_i ? uid_term : '0;
         default:  term_o = '0;
      endcase
   end

endmodule

// File: rtl/cksum_acc.sv
module cksum_acc #(
   parameter int unsigned SUM_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             add_i,
   input  logic [SUM_W-1:0] term_i,
   output logic [SUM_W-1:0] sum_o
);

   logic [SUM_W-1:0] acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc_q <= '0;
      else if (clear_i)
         acc_q <= '0;
      else if (add_i)
         acc_q <= acc_q + term_i;
   end

   assign sum_o = acc_q;

   // Nothing moves the sum except a clear or an add
   assert_sum_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear_i && !add_i) |=> $stable(acc_q));

endmodule

// File: rtl/cksum_engine.sv
module cksum_engine
   import cksum_pkg::*;
#(
   parameter int unsigned PROG_WORDS     = 1024,
   parameter int unsigned UID_WORDS      = 4,
   parameter int unsigned WORD_W         = 14,
   parameter int unsigned SUM_W          = 16,
   parameter int unsigned NIB_W          = 4,
   parameter int unsigned PACK_MSB_FIRST = 1,
   parameter int unsigned MASK_OPEN      = 'h3F79,
   parameter int unsigned MASK_PROT      = 'h3F39
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              protect_i,
   input  logic              word_valid_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [SUM_W-1:0]  sum_o,
   output logic              done_o
);

   localparam int unsigned UIDX_W = (UID_WORDS > 1) ? $clog2(UID_WORDS) : 1;

   // Elaboration-time parameter checks
   if (WORD_W > SUM_W) begin : g_chk_word
      $error("cksum_engine: WORD_W must not exceed SUM_W");
   end
   if (NIB_W * UID_WORDS > SUM_W) begin : g_chk_pack
      $error("cksum_engine: packed ID nibbles exceed SUM_W");
   end
   if (NIB_W > WORD_W || NIB_W == 0) begin : g_chk_nib
      $error("cksum_engine: NIB_W out of range");
   end
   if (PROG_WORDS == 0 || UID_WORDS == 0) begin : g_chk_cnt
      $error("cksum_engine: counts must be nonzero");
   end

   logic              prot_q;
   logic              busy;
   seg_e              seg;
   logic [UIDX_W-1:0] uid_idx;
   logic              take;
   logic              last;
   logic [SUM_W-1:0]  term;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         prot_q <= 1'b0;
      else if (start_i)
         prot_q <= protect_i;
   end

   cksum_seq #(
      .PROG_WORDS (PROG_WORDS),
      .UID_WORDS  (UID_WORDS)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .valid_i   (word_valid_i),
      .busy_o    (busy),
      .seg_o     (seg),
      .uid_idx_o (uid_idx),
      .take_o    (take),
      .last_o    (last),
      .done_o    (done_o)
   );

   cksum_term #(
      .WORD_W         (WORD_W),
      .SUM_W          (SUM_W),
      .UID_WORDS      (UID_WORDS),
      .NIB_W          (NIB_W),
      .PACK_MSB_FIRST (PACK_MSB_FIRST),
      .MASK_OPEN      (MASK_OPEN),
      .MASK_PROT      (MASK_PROT),
      .UIDX_W         (UIDX_W)
   ) u_term (
      .seg_i     (seg),
      .prot_i    (prot_q),
      .word_i    (word_i),
      .uid_idx_i (uid_idx),
      .term_o    (term)
   );

   cksum_acc #(
      .SUM_W (SUM_W)
   ) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (start_i),
      .add_i   (take),
      .term_i  (term),
      .sum_o   (sum_o)
   );

   // Result and flag frozen until the next start
   assert_result_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> (done_o && $stable(sum_o)));

   // Start wipes the previous result
   assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (!done_o && sum_o == '0));

   // Mode is frozen for the whole stream
   assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start_i) |=> $stable(prot_q));

   // Program words leave the sum alone under protection
   assert_prog_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (take && prot_q && seg == SEG_PROG) |=> $stable(sum_o));

   // User IDs leave the sum alone in open mode
   assert_uid_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !prot_q && seg == SEG_UID) |=> $stable(sum_o));

endmodule

// File: tb/cksum_engine_test.sv
module cksum_engine_test;

   localparam int CLK_PERIOD = 10;
   localparam int NPROG      = 1024;
   localparam int WATCHDOG   = 150000;

   typedef struct packed {
      logic        prot;
      logic        gaps;
      logic [13:0] fill;
      logic [13:0] first;
      logic [13:0] last;
      logic [13:0] cfg;
      logic [13:0] u0;
      logic [13:0] u1;
      logic [13:0] u2;
      logic [13:0] u3;
      logic [15:0] exp;
   } vec_t;

   localparam int NVEC = 7;
   localparam vec_t VECS [NVEC] = '{
      // open, blank image: FC00 + 3F79 wraps to 3B79
      '{1'b0, 1'b0, 14'h3FFF, 14'h3FFF, 14'h3FFF, 14'h3FFF, 14'h0, 14'h0, 14'h0, 14'h0, 16'h3B79},
      // open, 25E6 at both ends
      '{1'b0, 1'b1, 14'h3FFF, 14'h25E6, 14'h25E6, 14'h3FFF, 14'h0, 14'h0, 14'h0, 14'h0, 16'h0747},
      // protected, IDs 5 7 3 2
      '{1'b1, 1'b0, 14'h3FFF, 14'h3FFF, 14'h3FFF, 14'h3F7F, 14'h5, 14'h7, 14'h3, 14'h2, 16'h966B},
      // open, large IDs must be ignored
      '{1'b0, 1'b1, 14'h0000, 14'h0000, 14'h0000, 14'h0000, 14'h3FFF, 14'h3FFF, 14'h3FFF, 14'h3FFF, 16'h0000},
      // protected, only low nibbles: F000 + 0 + 0050 + 0001
      '{1'b1, 1'b0, 14'h1234, 14'h0ABC, 14'h2222, 14'h0000, 14'h000F, 14'h3FF0, 14'h00A5, 14'h0001, 16'hF051},
      // open, count of ones: 1024 = 0x0400
      '{1'b0, 1'b0, 14'h0001, 14'h0001, 14'h0001, 14'h0000, 14'h0, 14'h0, 14'h0, 14'h0, 16'h0400},
      // protected wrap: 3F39 + FFFF drops the carry
      '{1'b1, 1'b1, 14'h3FFF, 14'h3FFF, 14'h3FFF, 14'h3FFF, 14'h000F, 14'h000F, 14'h000F, 14'h000F, 16'h3F38}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        protect_i = 1'b0;
   logic        word_valid_i = 1'b0;
   logic [13:0] word_i = '0;
   logic [15:0] sum_o;
   logic        done_o;

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;

   cksum_engine uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .protect_i    (protect_i),
      .word_valid_i (word_valid_i),
      .word_i       (word_i),
      .sum_o        (sum_o),
      .done_o       (done_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic string vec_tag(input int i);
      case (i)
         0: return "R2,R5";
         1: return "R2,R6";
         2: return "R3,R4";
         3: return "R10,R2";
         4: return "R4,R10";
         5: return "R2";
         default: return "R5,R3";
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   task automatic pulse_start(input logic prot);
      @(negedge clk);
      start_i      = 1'b1;
      protect_i    = prot;
      word_valid_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   // Drive one word; optional idle cycle before it
   task automatic push(input logic [13:0] w, input bit gap);
      if (gap) begin
         word_valid_i = 1'b0;
         @(negedge clk);
      end
      word_valid_i = 1'b1;
      word_i       = w;
      @(negedge clk);
      word_valid_i = 1'b0;
   endtask

   // Streams a whole image; checks done is low just before the last word
   task automatic stream(input vec_t v);
      for (int a = 0; a < NPROG; a++) begin
         logic [13:0] w;
         w = (a == 0) ? v.first : (a == NPROG-1) ? v.last : v.fill;
         push(w, v.gaps && (a % 7 == 3));
      end
      push(v.cfg, v.gaps);
      push(v.u0, 1'b0);
      push(v.u1, v.gaps);
      push(v.u2, 1'b0);
      check(done_o == 1'b0, "R6 early done", {15'b0, done_o}, 16'h0);
      push(v.u3, v.gaps);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > WATCHDOG) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
            finish_run();
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(done_o == 1'b0, "R1 done", {15'b0, done_o}, 16'h0);
      check(sum_o == 16'h0, "R1 sum", sum_o, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // Vector table
      for (int i = 0; i < NVEC; i++) begin
         pulse_start(VECS[i].prot);
         stream(VECS[i]);
         check(done_o == 1'b1, {vec_tag(i), " done"}, {15'b0, done_o}, 16'h1);
         check(sum_o == VECS[i].exp, vec_tag(i), sum_o, VECS[i].exp);
      end

      // R7: words after completion are ignored, result held
      for (int k = 0; k < 5; k++) push(14'h3FFF, 1'b0);
      repeat (3) @(negedge clk);
      check(sum_o == VECS[NVEC-1].exp, "R7 held sum", sum_o, VECS[NVEC-1].exp);
      check(done_o == 1'b1, "R7 held done", {15'b0, done_o}, 16'h1);

      // R8: start clears result, then restart mid-image
      pulse_start(1'b0);
      check(done_o == 1'b0, "R8 clear done", {15'b0, done_o}, 16'h0);
      check(sum_o == 16'h0, "R8 clear sum", sum_o, 16'h0);
      for (int k = 0; k < 500; k++) push(14'h1111, 1'b0);
      pulse_start(1'b1);
      check(sum_o == 16'h0, "R8 restart sum", sum_o, 16'h0);
      stream(VECS[2]);
      check(sum_o == 16'h966B, "R8 restart result", sum_o, 16'h966B);

      // R8: a word in the start cycle is dropped
      @(negedge clk);
      start_i = 1'b1; protect_i = 1'b0; word_valid_i = 1'b1; word_i = 14'h3FFF;
      @(negedge clk);
      start_i = 1'b0; word_valid_i = 1'b0;
      check(sum_o == 16'h0, "R8 start word dropped", sum_o, 16'h0);
      stream(VECS[0]);
      check(sum_o == 16'h3B79, "R8 full after start word", sum_o, 16'h3B79);

      // R9: protect toggled mid-stream has no effect
      pulse_start(1'b0);
      protect_i = 1'b1;
      stream(VECS[0]);
      check(sum_o == 16'h3B79, "R9 mode captured", sum_o, 16'h3B79);

      // R7: idle valid words before start do nothing; result still held
      protect_i = 1'b0;
      push(14'h0123, 1'b0);
      check(sum_o == 16'h3B79, "R7 idle word ignored", sum_o, 16'h3B79);

      // R1: reset mid-operation returns outputs to zero
      rst_n = 1'b0;
      @(negedge clk);
      check(done_o == 1'b0 && sum_o == 16'h0, "R1 re-reset", sum_o, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);

      finish_run();
   end

endmodule